// File: doc/BRIEF.md
# Fetch-Stage Branch Direction and Target Predictor

This block tells the fetch stage, for a given fetch PC, whether to fetch down a branch's taken path and where that path starts, so fetch can run ahead of the branch before execute resolves it. Direction comes from a direct-mapped table of 2-bit saturating counters. The target comes from a small fully associative cache of targets from earlier taken branches. When that cache has no entry for the PC, a static rule decides instead: a negative displacement predicts taken and a non-negative one predicts not taken. The displacement is used only when fetch supplies a decoded one. Without a cached target and without a displacement, the block always answers not taken.

Lookups use a valid/ready request channel and a valid/ready response channel with a single response register. A request is accepted when `req_valid && req_ready`, and `req_ready` equals `!rsp_valid || rsp_ready`. The response appears on the cycle after acceptance. It stays unchanged while `rsp_ready` is low, so back-pressure on the response side stalls the request side directly. Resolved branches arrive from execute on an update channel whose `upd_ready` is always high: every beat with `upd_valid` high is applied at that clock edge. A lookup accepted in the same cycle as an update sees the tables as they were before that update.

Top module: `fetch_branch_predictor`

## Requirements
- R1: After reset every counter holds 1 (weakly not taken) and the target cache is empty, so every lookup gives not taken with fall-through target PC+4 unless the static rule applies; `rsp_valid` is 0 and `req_ready` is 1.
- R2: The counter for a PC is selected by PC bits [10:2], so PCs that agree in those bits share one counter. Counter values 2 and 3 predict taken and 0 and 1 predict not taken. This direction is used only when the target cache hits.
- R3: An update increments the selected counter when taken and decrements it when not taken, saturating at 3 and at 0.
- R4: The target cache hits when a valid entry's tag equals PC bits [31:2]. On a hit, `rsp_hit` is 1 and a taken prediction carries the stored target.
- R5: A not-taken update never allocates a target cache entry.
- R6: A taken update whose PC misses the cache allocates the entry under a round-robin pointer and then advances the pointer from entry 63 back to 0. The 65th distinct allocation therefore evicts the first.
- R7: On a cache miss with `req_off_vld` = 1, a negative `req_off` (bit 31 set) predicts taken with target `req_pc + req_off`. A non-negative one predicts not taken with target `req_pc + 4`.
- R8: On a cache miss with `req_off_vld` = 0, the prediction is not taken with target `req_pc + 4`. Whenever the prediction is not taken, the target is `req_pc + 4`.
- R9: The response is valid on the cycle after acceptance. While `rsp_valid && !rsp_ready`, `req_ready` is 0 and every response field holds its value.
- R10: A taken update whose PC hits the cache overwrites that entry's target and leaves the round-robin pointer where it is.
- R11: A lookup accepted in the same cycle as an update reflects the table state from before that update.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Lookup request valid |
| req_ready | output | 1 | Lookup request accepted when high |
| req_pc | input | 32 | Fetch PC of the lookup |
| req_off_vld | input | 1 | A decoded branch displacement is supplied |
| req_off | input | 32 | Two's complement branch displacement |
| rsp_valid | output | 1 | Prediction valid |
| rsp_ready | input | 1 | Consumer takes the prediction |
| rsp_taken | output | 1 | Predicted taken |
| rsp_target | output | 32 | Predicted next fetch address |
| rsp_hit | output | 1 | Target cache supplied the prediction |
| upd_valid | input | 1 | Resolved branch update valid |
| upd_ready | output | 1 | Always 1, no back-pressure on updates |
| upd_pc | input | 32 | PC of the resolved branch |
| upd_taken | input | 1 | Resolved outcome |
| upd_target | input | 32 | Resolved taken target |

## Verification
The hardest situation to reach is eviction by round-robin. The pointer cannot be seen from the ports, and it moves only on taken updates that miss. The stimulus fills the whole cache with 61 further distinct taken branches on top of those earlier scenarios placed, counting each allocation. It then shows the 65th replaces the oldest entry while a later one survives. Counter wrap-around is covered by update sequences that give a different prediction when a counter wraps instead of saturating. Sharing of counter indices is covered by two cached PCs 2 KiB apart.

// File: rtl/fbp_pkg.sv
package fbp_pkg;
  typedef logic [1:0] ctr_t;

  localparam ctr_t CTR_RESET = 2'd1;
  localparam ctr_t CTR_MAX   = 2'd3;
  localparam ctr_t CTR_MIN   = 2'd0;
  localparam int   INSN_BYTES = 4;

  function automatic ctr_t ctr_step(input ctr_t cur, input logic up);
    ctr_t nxt;
    if (up) nxt = (cur == CTR_MAX) ? CTR_MAX : cur + 2'd1;
    else    nxt = (cur == CTR_MIN) ? CTR_MIN : cur - 2'd1;
    return nxt;
  endfunction
endpackage

// File: rtl/fbp_counter_table.sv
module fbp_counter_table
  import fbp_pkg::*;
#(
  parameter int ENTRIES = 512,
  localparam int IDX_W = $clog2(ENTRIES)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [IDX_W-1:0] rd_idx,
  output logic             rd_taken,
  input  logic             upd_en,
  input  logic [IDX_W-1:0] upd_idx,
  input  logic             upd_taken
);
  ctr_t ctr_q [ENTRIES];

  assign rd_taken = ctr_q[rd_idx][1];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < ENTRIES; i++) ctr_q[i] <= CTR_RESET;
    end else if (upd_en) begin
      ctr_q[upd_idx] <= ctr_step(ctr_q[upd_idx], upd_taken);
    end
  end

  // Checker state: remembers the last update to compare against the table afterwards.
  logic             chk_v;
  logic             chk_tk;
  logic [IDX_W-1:0] chk_idx;
  ctr_t             chk_old;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      chk_v   <= 1'b0;
      chk_tk  <= 1'b0;
      chk_idx <= '0;
      chk_old <= CTR_RESET;
    end else begin
      chk_v   <= upd_en;
      chk_tk  <= upd_taken;
      chk_idx <= upd_idx;
      chk_old <= ctr_q[upd_idx];
    end
  end

  p_sat_high_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (chk_v && chk_tk && chk_old == CTR_MAX) |-> (ctr_q[chk_idx] == CTR_MAX));
  p_sat_low_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (chk_v && !chk_tk && chk_old == CTR_MIN) |-> (ctr_q[chk_idx] == CTR_MIN));
  p_step_up_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (chk_v && chk_tk && chk_old != CTR_MAX) |-> (ctr_q[chk_idx] == chk_old + 2'd1));
  p_step_dn_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (chk_v && !chk_tk && chk_old != CTR_MIN) |-> (ctr_q[chk_idx] == chk_old - 2'd1));
endmodule

// File: rtl/fbp_target_cache.sv
module fbp_target_cache #(
  parameter int ENTRIES = 64,
  parameter int AW      = 32,
  localparam int TAG_W  = AW - 2,
  localparam int PTR_W  = $clog2(ENTRIES)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [TAG_W-1:0] rd_tag,
  output logic             rd_hit,
  output logic [AW-1:0]    rd_target,
  input  logic             upd_en,
  input  logic [TAG_W-1:0] upd_tag,
  input  logic             upd_taken,
  input  logic [AW-1:0]    upd_target
);
  logic [ENTRIES-1:0] valid_q;
  logic [TAG_W-1:0]   tag_q [ENTRIES];
  logic [AW-1:0]      tgt_q [ENTRIES];
  logic [PTR_W-1:0]   rr_q;

  logic [ENTRIES-1:0] rd_vec;
  logic [ENTRIES-1:0] up_vec;
  logic               up_hit;
  logic [PTR_W-1:0]   up_idx;
  logic               wr_hit;
  logic               wr_alloc;

  for (genvar g = 0; g < ENTRIES; g++) begin : g_cmp
    assign rd_vec[g] = valid_q[g] && (tag_q[g] == rd_tag);
    assign up_vec[g] = valid_q[g] && (tag_q[g] == upd_tag);
  end

  assign rd_hit = |rd_vec;
  assign up_hit = |up_vec;

  always_comb begin
    rd_target = '0;
    for (int i = 0; i < ENTRIES; i++)
      if (rd_vec[i]) rd_target = rd_target | tgt_q[i];
  end

  always_comb begin
    up_idx = '0;
    for (int i = 0; i < ENTRIES; i++)
      if (up_vec[i]) up_idx = PTR_W'(i);
  end

  assign wr_hit   = upd_en && upd_taken && up_hit;
  assign wr_alloc = upd_en && upd_taken && !up_hit;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      valid_q <= '0;
      rr_q    <= '0;
    end else if (wr_alloc) begin
      valid_q[rr_q] <= 1'b1;
      rr_q <= (rr_q == PTR_W'(ENTRIES - 1)) ? '0 : rr_q + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (wr_alloc) begin
      tag_q[rr_q] <= upd_tag;
      tgt_q[rr_q] <= upd_target;
    end else if (wr_hit) begin
      tgt_q[up_idx] <= upd_target;
    end
  end

  p_tags_unique_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(rd_vec));
  p_no_alloc_nt_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (upd_en && !upd_taken) |=> $stable(valid_q));
  p_ptr_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !(upd_en && upd_taken && !up_hit) |=> $stable(rr_q));
endmodule

// File: rtl/fbp_static_rule.sv
module fbp_static_rule
  import fbp_pkg::*;
#(
  parameter int AW = 32
) (
  input  logic [AW-1:0] pc,
  input  logic          off_vld,
  input  logic [AW-1:0] off,
  output logic          taken,
  output logic [AW-1:0] target
);
  logic [AW-1:0] fall_through;
  logic [AW-1:0] jump_to;

  assign fall_through = pc + AW'(INSN_BYTES);
  assign jump_to      = pc + off;
  assign taken        = off_vld && off[AW-1];
  assign target       = taken ? jump_to : fall_through;
endmodule

// File: rtl/fetch_branch_predictor.sv
module fetch_branch_predictor
  import fbp_pkg::*;
#(
  parameter int AW          = 32,
  parameter int BHT_ENTRIES = 512,
  parameter int TGT_ENTRIES = 64,
  localparam int IDX_W      = $clog2(BHT_ENTRIES),
  localparam int TAG_W      = AW - 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req_valid,
  output logic          req_ready,
  input  logic [AW-1:0] req_pc,
  input  logic          req_off_vld,
  input  logic [AW-1:0] req_off,
  output logic          rsp_valid,
  input  logic          rsp_ready,
  output logic          rsp_taken,
  output logic [AW-1:0] rsp_target,
  output logic          rsp_hit,
  input  logic          upd_valid,
  output logic          upd_ready,
  input  logic [AW-1:0] upd_pc,
  input  logic          upd_taken,
  input  logic [AW-1:0] upd_target
);
  logic          ctr_taken;
  logic          tc_hit;
  logic [AW-1:0] tc_target;
  logic          st_taken;
  logic [AW-1:0] st_target;
  logic          nx_taken;
  logic [AW-1:0] nx_target;
  logic          req_fire;
  logic          unused_upd_lsb;

  assign unused_upd_lsb = ^upd_pc[1:0];
  assign upd_ready      = 1'b1;

  fbp_counter_table #(.ENTRIES(BHT_ENTRIES)) u_ctr (
    .clk       (clk),
    .rst_n     (rst_n),
    .rd_idx    (req_pc[IDX_W+1:2]),
    .rd_taken  (ctr_taken),
    .upd_en    (upd_valid),
    .upd_idx   (upd_pc[IDX_W+1:2]),
    .upd_taken (upd_taken)
  );

  fbp_target_cache #(.ENTRIES(TGT_ENTRIES), .AW(AW)) u_tc (
    .clk        (clk),
    .rst_n      (rst_n),
    .rd_tag     (req_pc[AW-1:2]),
    .rd_hit     (tc_hit),
    .rd_target  (tc_target),
    .upd_en     (upd_valid),
    .upd_tag    (upd_pc[AW-1:2]),
    .upd_taken  (upd_taken),
    .upd_target (upd_target)
  );

  fbp_static_rule #(.AW(AW)) u_static (
    .pc      (req_pc),
    .off_vld (req_off_vld),
    .off     (req_off),
    .taken   (st_taken),
    .target  (st_target)
  );

  always_comb begin
    if (tc_hit) begin
      nx_taken  = ctr_taken;
      nx_target = ctr_taken ? tc_target : req_pc + AW'(INSN_BYTES);
    end else begin
      nx_taken  = st_taken;
      nx_target = st_target;
    end
  end

  assign req_ready = !rsp_valid || rsp_ready;
  assign req_fire  = req_valid && req_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
    end else if (req_ready) begin
      rsp_valid <= req_valid;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rsp_taken  <= 1'b0;
      rsp_target <= '0;
      rsp_hit    <= 1'b0;
    end else if (req_fire) begin
      rsp_taken  <= nx_taken;
      rsp_target <= nx_target;
      rsp_hit    <= tc_hit;
    end
  end

  p_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_ready) |=> (rsp_valid && $stable(rsp_taken)
                                   && $stable(rsp_target) && $stable(rsp_hit)));
  p_stall_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_ready) |-> !req_ready);
  p_resp_follows_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready) |=> rsp_valid);
endmodule

// File: tb/fetch_branch_predictor_bench.sv
`timescale 1ns/1ps
module fetch_branch_predictor_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic [31:0] req_pc = '0;
  logic        req_off_vld = 1'b0;
  logic [31:0] req_off = '0;
  logic        rsp_valid;
  logic        rsp_ready = 1'b1;
  logic        rsp_taken;
  logic [31:0] rsp_target;
  logic        rsp_hit;
  logic        upd_valid = 1'b0;
  logic        upd_ready;
  logic [31:0] upd_pc = '0;
  logic        upd_taken = 1'b0;
  logic [31:0] upd_target = '0;

  int checks = 0;
  int fails  = 0;

  always #4 clk = ~clk;

  fetch_branch_predictor u_fetch_branch_predictor (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_ready(req_ready), .req_pc(req_pc),
    .req_off_vld(req_off_vld), .req_off(req_off),
    .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_taken(rsp_taken),
    .rsp_target(rsp_target), .rsp_hit(rsp_hit),
    .upd_valid(upd_valid), .upd_ready(upd_ready), .upd_pc(upd_pc),
    .upd_taken(upd_taken), .upd_target(upd_target)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic lookup(input logic [31:0] pc, input logic ov, input logic [31:0] off,
                        input string tag, input logic et, input logic [31:0] eg,
                        input logic eh);
    @(negedge clk);
    req_valid = 1'b1; req_pc = pc; req_off_vld = ov; req_off = off;
    @(negedge clk);
    req_valid = 1'b0;
    check({tag, " valid"}, 32'(rsp_valid), 32'd1);
    check({tag, " taken"}, 32'(rsp_taken), 32'(et));
    check({tag, " target"}, rsp_target, eg);
    check({tag, " hit"}, 32'(rsp_hit), 32'(eh));
  endtask

  task automatic update(input logic [31:0] pc, input logic tk, input logic [31:0] tg);
    @(negedge clk);
    upd_valid = 1'b1; upd_pc = pc; upd_taken = tk; upd_target = tg;
    @(negedge clk);
    upd_valid = 1'b0;
  endtask

  task automatic t_reset();
    check("R1 rsp_valid after reset", 32'(rsp_valid), 32'd0);
    check("R1 req_ready after reset", 32'(req_ready), 32'd1);
    check("R1 upd_ready", 32'(upd_ready), 32'd1);
    lookup(32'h1000, 1'b0, 32'h0, "R1 empty lookup", 1'b0, 32'h1004, 1'b0);
  endtask

  task automatic t_static();
    lookup(32'h2000, 1'b1, 32'hFFFF_FFF0, "R7 backward", 1'b1, 32'h1FF0, 1'b0);
    lookup(32'h2000, 1'b1, 32'h0000_0020, "R7 forward", 1'b0, 32'h2004, 1'b0);
    lookup(32'h2000, 1'b1, 32'h0, "R7 zero", 1'b0, 32'h2004, 1'b0);
    lookup(32'h2000, 1'b0, 32'hFFFF_FFF0, "R8 no displacement", 1'b0, 32'h2004, 1'b0);
  endtask

  task automatic t_allocate();
    update(32'h3000, 1'b1, 32'h3400);
    lookup(32'h3000, 1'b0, 32'h0, "R4 hit after taken", 1'b1, 32'h3400, 1'b1);
    update(32'h3000, 1'b0, 32'h0);
    lookup(32'h3000, 1'b0, 32'h0, "R2 counter 1 predicts not taken", 1'b0, 32'h3004, 1'b1);
  endtask

  task automatic t_saturate();
    for (int i = 0; i < 4; i++) update(32'h4008, 1'b1, 32'h5000);
    update(32'h4008, 1'b0, 32'h0);
    lookup(32'h4008, 1'b0, 32'h0, "R3 top saturation", 1'b1, 32'h5000, 1'b1);
    for (int i = 0; i < 3; i++) update(32'h4008, 1'b0, 32'h0);
    update(32'h4008, 1'b1, 32'h5000);
    lookup(32'h4008, 1'b0, 32'h0, "R3 bottom saturation", 1'b0, 32'h400C, 1'b1);
    update(32'h4008, 1'b1, 32'h5000);
    lookup(32'h4008, 1'b0, 32'h0, "R3 climb to 2", 1'b1, 32'h5000, 1'b1);
  endtask

  task automatic t_no_alloc_nt();
    update(32'h6010, 1'b0, 32'hABCD_0000);
    lookup(32'h6010, 1'b1, 32'hFFFF_FFF8, "R5 not-taken leaves no entry", 1'b1, 32'h6008, 1'b0);
  endtask

  task automatic t_overwrite();
    update(32'h3000, 1'b1, 32'h3800);
    lookup(32'h3000, 1'b0, 32'h0, "R10 target overwritten", 1'b1, 32'h3800, 1'b1);
  endtask

  task automatic t_alias();
    update(32'h3800, 1'b1, 32'h9000);
    update(32'h3800, 1'b0, 32'h0);
    update(32'h3800, 1'b0, 32'h0);
    lookup(32'h3000, 1'b0, 32'h0, "R2 shared counter index", 1'b0, 32'h3004, 1'b1);
    lookup(32'h3800, 1'b0, 32'h0, "R4 second entry", 1'b0, 32'h3804, 1'b1);
  endtask

  task automatic t_round_robin();
    // Entries 0..2 are in use; 61 more fill 3..63, the next replaces entry 0.
    for (int i = 0; i < 61; i++)
      update(32'h20000 + 32'(i) * 32'h1000, 1'b1, 32'h0090_0000 + 32'(i) * 32'h10);
    lookup(32'h3000, 1'b0, 32'h0, "R6 oldest kept before wrap", 1'b1, 32'h3800, 1'b1);
    update(32'h20000 + 32'd61 * 32'h1000, 1'b1, 32'h00AA_0000);
    lookup(32'h3000, 1'b1, 32'hFFFF_FF00, "R6 oldest evicted", 1'b1, 32'h2F00, 1'b0);
    lookup(32'h4008, 1'b0, 32'h0, "R6 second entry kept", 1'b1, 32'h5000, 1'b1);
    lookup(32'h20000 + 32'd61 * 32'h1000, 1'b0, 32'h0, "R6 new entry", 1'b1, 32'h00AA_0000, 1'b1);
    lookup(32'h20000 + 32'd60 * 32'h1000, 1'b0, 32'h0, "R6 last fill kept", 1'b1,
           32'h0090_0000 + 32'd60 * 32'h10, 1'b1);
  endtask

  task automatic t_backpressure();
    @(negedge clk);
    rsp_ready = 1'b0; req_valid = 1'b1; req_pc = 32'h7000; req_off_vld = 1'b0;
    @(negedge clk);
    check("R9 valid after accept", 32'(rsp_valid), 32'd1);
    check("R9 stall drops req_ready", 32'(req_ready), 32'd0);
    check("R9 first target", rsp_target, 32'h7004);
    req_pc = 32'h7100;
    @(negedge clk);
    check("R9 held target", rsp_target, 32'h7004);
    check("R9 held valid", 32'(rsp_valid), 32'd1);
    rsp_ready = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
    check("R9 next accepted", rsp_target, 32'h7104);
  endtask

  task automatic t_same_cycle();
    @(negedge clk);
    req_valid = 1'b1; req_pc = 32'h8000; req_off_vld = 1'b0;
    upd_valid = 1'b1; upd_pc = 32'h8000; upd_taken = 1'b1; upd_target = 32'h8800;
    @(negedge clk);
    req_valid = 1'b0; upd_valid = 1'b0;
    check("R11 sees old state hit", 32'(rsp_hit), 32'd0);
    check("R11 sees old state target", rsp_target, 32'h8004);
    lookup(32'h8000, 1'b0, 32'h0, "R11 update visible afterwards", 1'b1, 32'h8800, 1'b1);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_static();
    t_allocate();
    t_saturate();
    t_no_alloc_nt();
    t_overwrite();
    t_alias();
    t_round_robin();
    t_backpressure();
    t_same_cycle();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule